// File: doc/BRIEF.md
# Host Interrupt Mailbox Controller

This block sits between a network controller's datapath and the host driver. It owns the host-visible interrupt mailbox, a 32-bit register. Any host write to it clears the interrupt, whatever value is written. A nonzero value in it tells the hardware that the host is inside its interrupt service routine.

A coalescing unit counts datapath events, and timer ticks while events are outstanding. It compares both counts against one of two threshold sets. The normal set applies while the mailbox is zero and the in-service set applies while it is nonzero. When a threshold is reached, the unit issues a one-cycle status-writeback pulse. That pulse sets an internal pending flag, but only while the mailbox is zero. The pending flag drives the active-low interrupt line whenever the host mask bit is clear.

Top module: `irq_mailbox_ctrl`

## Requirements
- R1: After reset, the mailbox reads zero, the mask bit is set, the pending flag and both counters are zero, `wb_pulse` is low and `irq_n` is high.
- R2: A host mailbox write loads `mbox_value` on the next cycle and clears the pending flag, whatever data is written, zero included. The mailbox changes only on a write.
- R3: A writeback taken while the mask is set sets the pending flag and leaves `irq_n` high. `irq_n` falls in the cycle after the mask is cleared.
- R4: If a mailbox write clears the pending flag while the mask is set, a later clearing of the mask does not drive `irq_n` low.
- R5: While `mbox_value` is nonzero, a writeback sets no pending flag and cannot pull `irq_n` low.
- R6: `isr_set_active` is 1 exactly when `mbox_value` is nonzero. While it is 1, the coalescing unit compares against the in-service thresholds; otherwise it compares against the normal thresholds.
- R7: When the event count including the current cycle's event reaches a nonzero event threshold, `wb_pulse` is high in the next cycle. Both counters then restart from zero.
- R8: The tick counter advances on `tick_in` only while at least one event has already been counted. When it reaches a nonzero tick threshold, `wb_pulse` follows in the next cycle.
- R9: A zero threshold disables its trigger. When both thresholds of the selected set are zero, every event produces a writeback pulse in the next cycle.
- R10: When a mailbox write and `wb_pulse` coincide, the clear takes effect first. The pulse then sets the pending flag only if the written value is zero.
- R11: Writebacks suppressed while the mailbox was nonzero are not replayed when the mailbox returns to zero.
- R12: `irq_n` is low exactly when the pending flag is set and the mask bit is clear. Counters saturate at their maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mbox_wr_en | input | 1 | Host write strobe for the mailbox |
| mbox_wr_data | input | 32 | Data of the mailbox write |
| mask_wr_en | input | 1 | Host write strobe for the mask bit |
| mask_wr_data | input | 1 | New mask value (1 = interrupt masked) |
| evt_in | input | 1 | One datapath event this cycle |
| tick_in | input | 1 | Coalescing timer tick |
| norm_max_evt | input | 8 | Event threshold, normal set |
| norm_max_tick | input | 8 | Tick threshold, normal set |
| isr_max_evt | input | 8 | Event threshold, in-service set |
| isr_max_tick | input | 8 | Tick threshold, in-service set |
| mbox_value | output | 32 | Current mailbox contents |
| isr_set_active | output | 1 | In-service threshold set selected |
| wb_pulse | output | 1 | Status writeback pulse |
| irq_n | output | 1 | Level interrupt, active low |

## Verification
The assertions check four rules on every cycle. The mailbox changes only after a write. A nonzero write always leaves the line released. A nonzero mailbox never lets the line fall. The line is never low while the mask is set. They also check the coincident write-and-pulse ordering when the written value is zero.

The bench scenarios show the behaviours that span several host actions. These are masked pending followed by a later unmask, and a clear made while masked that must stay silent after unmasking. The scenarios also cover event and tick thresholds, the all-zero threshold case, the switch between threshold sets, and the absence of replay once the mailbox returns to zero.

// File: rtl/irq_mbox_pkg.sv
// Package: shared widths for the interrupt mailbox controller.
// Assumes every user takes its widths from these defaults, or overrides them consistently.
package irq_mbox_pkg;
    localparam int MBOX_W_DEF = 32;
    localparam int CNT_W_DEF  = 8;

    // Selects which threshold set the coalescing unit compares against.
    typedef enum logic {
        SET_NORMAL = 1'b0,
        SET_ISR    = 1'b1
    } thr_set_e;
endpackage

// File: rtl/mbox_reg.sv
// Module: mbox_reg
// Holds the host mailbox and the mask bit.
// Assumes host writes arrive as single-cycle strobes.
module mbox_reg #(
    parameter int MBOX_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mbox_wr_en,
    input  logic [MBOX_W-1:0] mbox_wr_data,
    input  logic              mask_wr_en,
    input  logic              mask_wr_data,
    output logic [MBOX_W-1:0] mbox_q,
    output logic              mask_q,
    output logic              busy
);
    // Purpose: load the mailbox on a host write.
    always_ff @(posedge clk) begin
        if (!rst_n)          mbox_q <= '0;
        else if (mbox_wr_en) mbox_q <= mbox_wr_data;
    end

    // Purpose: hold the mask bit, which resets to masked.
    always_ff @(posedge clk) begin
        if (!rst_n)          mask_q <= 1'b1;
        else if (mask_wr_en) mask_q <= mask_wr_data;
    end

    // Purpose: flag that the host is inside its service routine.
    assign busy = (mbox_q != '0);
endmodule

// File: rtl/coalesce_unit.sv
// Module: coalesce_unit
// Counts events, and ticks while events are outstanding. Compares them against the
// selected threshold set and emits a registered one-cycle writeback pulse.
// Assumes thresholds are quasi-static; a zero threshold disables its trigger.
module coalesce_unit
    import irq_mbox_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_in,
    input  logic             tick_in,
    input  thr_set_e         sel,
    input  logic [CNT_W-1:0] norm_max_evt,
    input  logic [CNT_W-1:0] norm_max_tick,
    input  logic [CNT_W-1:0] isr_max_evt,
    input  logic [CNT_W-1:0] isr_max_tick,
    output logic             wb_pulse
);
    localparam logic [CNT_W:0] ONE = {{CNT_W{1'b0}}, 1'b1};

    logic [CNT_W-1:0] evt_q, tick_q, lim_evt, lim_tick, evt_nx, tick_nx;
    logic [CNT_W:0]   evt_sum, tick_sum;
    logic             tick_adv, fire;

    // Purpose: pick the active thresholds and form the saturating next counts and the trigger.
    always_comb begin
        lim_evt  = (sel == SET_ISR) ? isr_max_evt  : norm_max_evt;
        lim_tick = (sel == SET_ISR) ? isr_max_tick : norm_max_tick;
        tick_adv = tick_in && (evt_q != '0);
        evt_sum  = {1'b0, evt_q}  + (evt_in   ? ONE : '0);
        tick_sum = {1'b0, tick_q} + (tick_adv ? ONE : '0);
        evt_nx   = evt_sum[CNT_W]  ? '1 : evt_sum[CNT_W-1:0];
        tick_nx  = tick_sum[CNT_W] ? '1 : tick_sum[CNT_W-1:0];
        fire     = ((lim_evt  != '0) && (evt_nx  >= lim_evt))  ||
                   ((lim_tick != '0) && (tick_nx >= lim_tick)) ||
                   ((lim_evt == '0) && (lim_tick == '0) && evt_in);
    end

    // Purpose: advance the counters, restarting them on a writeback.
    always_ff @(posedge clk) begin
        if (!rst_n || fire) begin
            evt_q  <= '0;
            tick_q <= '0;
        end else begin
            evt_q  <= evt_nx;
            tick_q <= tick_nx;
        end
    end

    // Purpose: register the writeback pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) wb_pulse <= 1'b0;
        else        wb_pulse <= fire;
    end
endmodule

// File: rtl/irq_pending.sv
// Module: irq_pending
// Keeps the pending-interrupt flag and drives the active-low interrupt line.
// Assumes a mailbox write takes priority over a writeback in the same cycle.
module irq_pending (
    input  logic clk,
    input  logic rst_n,
    input  logic mbox_wr_en,
    input  logic wr_is_zero,
    input  logic wb_pulse,
    input  logic busy,
    input  logic mask_q,
    output logic irq_n
);
    logic pend_q;

    // Purpose: clear on any mailbox write, then set on a writeback if the mailbox is (or becomes) zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          pend_q <= 1'b0;
        else if (mbox_wr_en) pend_q <= wb_pulse && wr_is_zero;
        else if (wb_pulse && !busy) pend_q <= 1'b1;
    end

    // Purpose: drive the line low only while pending and unmasked.
    assign irq_n = ~(pend_q & ~mask_q);
endmodule

// File: rtl/irq_mailbox_ctrl.sv
// Module: irq_mailbox_ctrl (top)
// Host interrupt mailbox with two-set coalescing and a masked, active-low interrupt line.
// Assumes the host writes the mailbox and the mask through single-cycle strobes.
module irq_mailbox_ctrl
    import irq_mbox_pkg::*;
#(
    parameter int MBOX_W = MBOX_W_DEF,
    parameter int CNT_W  = CNT_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mbox_wr_en,
    input  logic [MBOX_W-1:0] mbox_wr_data,
    input  logic              mask_wr_en,
    input  logic              mask_wr_data,
    input  logic              evt_in,
    input  logic              tick_in,
    input  logic [CNT_W-1:0]  norm_max_evt,
    input  logic [CNT_W-1:0]  norm_max_tick,
    input  logic [CNT_W-1:0]  isr_max_evt,
    input  logic [CNT_W-1:0]  isr_max_tick,
    output logic [MBOX_W-1:0] mbox_value,
    output logic              isr_set_active,
    output logic              wb_pulse,
    output logic              irq_n
);
    logic     mask_q, busy;
    thr_set_e sel;

    mbox_reg #(.MBOX_W(MBOX_W)) u_mbox (
        .clk(clk), .rst_n(rst_n),
        .mbox_wr_en(mbox_wr_en), .mbox_wr_data(mbox_wr_data),
        .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
        .mbox_q(mbox_value), .mask_q(mask_q), .busy(busy)
    );

    assign sel            = busy ? SET_ISR : SET_NORMAL;
    assign isr_set_active = (sel == SET_ISR);

    coalesce_unit #(.CNT_W(CNT_W)) u_coal (
        .clk(clk), .rst_n(rst_n),
        .evt_in(evt_in), .tick_in(tick_in), .sel(sel),
        .norm_max_evt(norm_max_evt), .norm_max_tick(norm_max_tick),
        .isr_max_evt(isr_max_evt), .isr_max_tick(isr_max_tick),
        .wb_pulse(wb_pulse)
    );

    irq_pending u_pend (
        .clk(clk), .rst_n(rst_n),
        .mbox_wr_en(mbox_wr_en), .wr_is_zero(mbox_wr_data == '0),
        .wb_pulse(wb_pulse), .busy(busy), .mask_q(mask_q),
        .irq_n(irq_n)
    );
endmodule

// File: rtl/irq_mailbox_checker.sv
// Module: irq_mailbox_checker
// Cycle-level properties of the mailbox controller, attached by bind.
// Assumes it sees the top's ports and its internal mask register.
module irq_mailbox_checker #(
    parameter int MBOX_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mbox_wr_en,
    input logic [MBOX_W-1:0] mbox_wr_data,
    input logic              mask_wr_en,
    input logic [MBOX_W-1:0] mbox_value,
    input logic              wb_pulse,
    input logic              irq_n,
    input logic              mask_q
);
    // R2: the mailbox changes only as a result of a write in the previous cycle
    a_r2_change_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mbox_wr_en |=> $stable(mbox_value));

    // R2: a nonzero write always leaves the line released
    a_r2_nonzero_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_wr_en && mbox_wr_data != '0) |=> irq_n);

    // R5: a nonzero mailbox never lets the line fall without a host write
    a_r5_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_value != '0 && !mbox_wr_en && !mask_wr_en && irq_n) |=> irq_n);

    // R12: the line is never low while masked
    a_r12_mask_gates: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> !mask_q);

    // R10: a zero write coinciding with a pulse leaves pending set
    a_r10_same_cycle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_wr_en && wb_pulse && mbox_wr_data == '0 && !mask_q && !mask_wr_en) |=> !irq_n);
endmodule

bind irq_mailbox_ctrl irq_mailbox_checker #(.MBOX_W(MBOX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mbox_wr_en(mbox_wr_en), .mbox_wr_data(mbox_wr_data),
    .mask_wr_en(mask_wr_en), .mbox_value(mbox_value), .wb_pulse(wb_pulse),
    .irq_n(irq_n), .mask_q(mask_q)
);

// File: tb/irq_mailbox_ctrl_tb.sv
module irq_mailbox_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mbox_wr_en = 1'b0, mask_wr_en = 1'b0, mask_wr_data = 1'b0;
    logic [31:0] mbox_wr_data = '0;
    logic        evt_in = 1'b0, tick_in = 1'b0;
    logic [7:0]  norm_max_evt = 8'd3, norm_max_tick = 8'd0, isr_max_evt = 8'd2, isr_max_tick = 8'd0;
    logic [31:0] mbox_value;
    logic        isr_set_active, wb_pulse, irq_n;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // reference state, from the requirements
    logic [31:0] m_mbox = '0;
    bit m_mask = 1'b1, m_pend = 1'b0, m_wb = 1'b0;
    int m_evt = 0, m_tick = 0;

    always #10 clk = ~clk;

    irq_mailbox_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .mbox_wr_en(mbox_wr_en), .mbox_wr_data(mbox_wr_data),
        .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data), .evt_in(evt_in), .tick_in(tick_in),
        .norm_max_evt(norm_max_evt), .norm_max_tick(norm_max_tick),
        .isr_max_evt(isr_max_evt), .isr_max_tick(isr_max_tick),
        .mbox_value(mbox_value), .isr_set_active(isr_set_active),
        .wb_pulse(wb_pulse), .irq_n(irq_n)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_irq_n();
        return !(m_pend && !m_mask);
    endfunction

    // advance the reference by one clock with the currently driven inputs
    task automatic model_step();
        int le, lt, en, tn;
        bit fire;
        if (!rst_n) begin
            m_mbox = '0; m_mask = 1'b1; m_pend = 1'b0; m_wb = 1'b0; m_evt = 0; m_tick = 0;
            return;
        end
        le = (m_mbox != 0) ? isr_max_evt  : norm_max_evt;   // R6 set selection
        lt = (m_mbox != 0) ? isr_max_tick : norm_max_tick;
        en = m_evt + evt_in; if (en > 255) en = 255;
        tn = m_tick + ((tick_in && m_evt != 0) ? 1 : 0); if (tn > 255) tn = 255;
        fire = (le != 0 && en >= le) || (lt != 0 && tn >= lt) || (le == 0 && lt == 0 && evt_in);
        if (mbox_wr_en) m_pend = m_wb && (mbox_wr_data == 0);
        else if (m_wb && m_mbox == 0) m_pend = 1'b1;
        if (mbox_wr_en) m_mbox = mbox_wr_data;
        if (mask_wr_en) m_mask = mask_wr_data;
        m_evt  = fire ? 0 : en;
        m_tick = fire ? 0 : tn;
        m_wb   = fire;
    endtask

    // one clock: drive at negedge, compare at the following negedge
    task automatic cyc(input bit wr, input logic [31:0] d, input bit mw, input bit md,
                       input bit ev, input bit tk);
        mbox_wr_en = wr; mbox_wr_data = d; mask_wr_en = mw; mask_wr_data = md;
        evt_in = ev; tick_in = tk;
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk(mbox_value == m_mbox, "R2", mbox_value, m_mbox);
        chk(isr_set_active == (m_mbox != 0), "R6", isr_set_active, m_mbox != 0);
        chk(wb_pulse == m_wb, "R7", wb_pulse, m_wb);
        chk(irq_n == exp_irq_n(), "R12", irq_n, exp_irq_n());
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 0);
        rst_n = 1'b1;
        // R1: reset state
        chk(irq_n == 1 && mbox_value == 0 && wb_pulse == 0 && isr_set_active == 0, "R1",
            {irq_n, wb_pulse, isr_set_active}, 3'b100);
        cyc(0, 0, 1, 0, 0, 0);                  // unmask
        // R7: three events reach the normal threshold of 3
        cyc(0, 0, 0, 0, 1, 0); cyc(0, 0, 0, 0, 1, 0);
        chk(wb_pulse == 0, "R7", wb_pulse, 0);
        cyc(0, 0, 0, 0, 1, 0);
        chk(wb_pulse == 1, "R7", wb_pulse, 1);
        idle(1);
        chk(irq_n == 0, "R12", irq_n, 0);
        // R2: writing zero still clears
        cyc(1, 0, 0, 0, 0, 0);
        chk(irq_n == 1, "R2", irq_n, 1);
        // R3: masked writeback stays pending
        cyc(0, 0, 1, 1, 1, 0); cyc(0, 0, 0, 0, 1, 0); cyc(0, 0, 0, 0, 1, 0); idle(2);
        chk(irq_n == 1, "R3", irq_n, 1);
        cyc(0, 0, 1, 0, 0, 0);
        chk(irq_n == 0, "R3", irq_n, 0);
        // R4: clear while masked, then unmask
        cyc(1, 0, 1, 1, 0, 0);
        cyc(0, 0, 0, 0, 1, 0); cyc(0, 0, 0, 0, 1, 0); cyc(0, 0, 0, 0, 1, 0); idle(1);
        cyc(1, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0); idle(1);
        chk(irq_n == 1, "R4", irq_n, 1);
        // R6 and R5: in-service set with threshold 2, interrupt suppressed
        cyc(1, 32'h5, 0, 0, 0, 0);
        chk(isr_set_active == 1, "R6", isr_set_active, 1);
        cyc(0, 0, 0, 0, 1, 0); cyc(0, 0, 0, 0, 1, 0);
        chk(wb_pulse == 1, "R6", wb_pulse, 1);
        idle(2);
        chk(irq_n == 1, "R5", irq_n, 1);
        // R11: returning to zero replays nothing
        cyc(1, 0, 0, 0, 0, 0); idle(4);
        chk(irq_n == 1, "R11", irq_n, 1);
        // R8: tick threshold 4, event threshold disabled
        norm_max_evt = 8'd0; norm_max_tick = 8'd4;
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, 1);
        chk(wb_pulse == 0, "R8", wb_pulse, 0);
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0, 1);
        chk(wb_pulse == 0, "R8", wb_pulse, 0);
        cyc(0, 0, 0, 0, 0, 1);
        chk(wb_pulse == 1, "R8", wb_pulse, 1);
        cyc(1, 0, 0, 0, 0, 0);
        // R9: both thresholds zero, every event writes back
        norm_max_tick = 8'd0;
        cyc(0, 0, 0, 0, 1, 0);
        chk(wb_pulse == 1, "R9", wb_pulse, 1);
        // R10: the pulse is visible now; a zero write in this cycle keeps it pending
        cyc(1, 0, 0, 0, 0, 0);
        chk(irq_n == 0, "R10", irq_n, 0);
        cyc(0, 0, 0, 0, 1, 0);
        cyc(1, 32'h7, 0, 0, 0, 0);
        chk(irq_n == 1, "R10", irq_n, 1);
        cyc(1, 0, 0, 0, 0, 0);
        // random phase, fixed seed
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            if (i % 400 == 0) begin
                norm_max_evt = $urandom_range(0, 5); norm_max_tick = $urandom_range(0, 5);
                isr_max_evt  = $urandom_range(0, 5); isr_max_tick  = $urandom_range(0, 5);
            end
            cyc(($urandom_range(0, 15) == 0), (($urandom_range(0, 1) == 0) ? 32'h0 : $urandom),
                ($urandom_range(0, 11) == 0), $urandom_range(0, 1),
                $urandom_range(0, 1), ($urandom_range(0, 2) == 0));
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule